// File: doc/BRIEF.md
# Heartbeat Vsync Timer Bank

This block produces substitute vsync pulses for command-mode display pipelines whose panel gives no tearing-effect signal. A bank of five independent down-counting timers shares one prescaler. The prescaler divides the reference clock by sixteen to make a single-cycle tick. Each timer reloads from a software-written value. With the 19.2 MHz reference, software writes 1000 x 19200 / (16 x fps) as that value, which is 20000 ticks at 60 fps. When heartbeat generation is on, each expiry emits a pulse one tick wide.

Five pipeline outputs each carry a 4-bit source code. The code routes that output to one of the timer pulses or to the external tearing-effect input. Software reaches the block through a flat word-addressed register port. Timer n owns word addresses 4n (control), 4n+1 (second control) and 4n+2 (load value). Address 20 holds the whole selection register, and address 21 updates one output's code and leaves the others alone.

Top module: `hb_vsync_gen`

## Requirements
- R1: The tick strobe is high for one clock in every 16, first at the 16th rising edge after reset release. A timer's count and pulse change only on a tick edge or a clear.
- R2: With the enable (second control bit 0) and heartbeat (second control bit 8) set and a nonzero load L, a timer cleared by writing 1 to bit 0 of its control word raises its pulse on the L-th tick after the clear. The pulse stays high for exactly one tick (16 clocks) and repeats every L ticks.
- R3: With the enable set and heartbeat clear, the timer keeps counting but its pulse stays low.
- R4: With the enable clear, or with a load value of zero, the timer holds its count and its pulse is low from the next clock on.
- R5: A new load value written during a count takes effect only at the next reload or clear. Once it takes effect, pulses are L_new x 16 clocks apart.
- R6: Source codes 0 to 4 route timer 0 to 4, code 5 routes the tearing-effect input `teIn`, and codes 6 to 15 give a constant low output.
- R7: In the selection word at address 20, the codes of outputs 0, 1, 2, 3 and 4 sit at bits [15:12], [11:8], [7:4], [22:19] and [27:24]. Every other bit reads as zero.
- R8: A write to address 21 with the output index in bits [2:0] and the code in bits [7:4] changes only that output's code. Indices 5 to 7 change nothing.
- R9: Reset clears every register field and every timer. All outputs are then low, all codes are 0, and every readback is zero.
- R10: The second control word reads back as bit 0 = enable and bit 8 = heartbeat, and the load word reads back its low 16 bits. The control word always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 5 | Word address for writes and reads |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| teIn | input | 1 | External tearing-effect input, selectable as source code 5 |
| vsyncOut | output | 5 | Routed vsync for pipeline outputs 0 to 4 |

## Verification
A register write takes effect at the clock edge that samples it. Readback and the routing from `teIn` are combinational, so they are due in the same cycle. A timer pulse changes only at a tick edge, one register stage after the prescaler reaches 15, and it lasts the 16 clocks up to the next tick. A behavioural model in the bench applies the same edge rules to its own counters at each rising edge. The bench compares every output at the following falling edge, which is the point where each of those results has settled.

// File: rtl/hbvs_pkg.sv
package hbvs_pkg;
  localparam int NUM_TMR    = 5;
  localparam int NUM_OUT    = 5;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 5;
  localparam int LOAD_W     = 16;
  localparam int CODE_W     = 4;
  localparam int PRESCALE   = 16;
  localparam int SUB_CTL    = 0;
  localparam int SUB_CTL2   = 1;
  localparam int SUB_LOAD   = 2;
  localparam int SEL_ADDR   = NUM_TMR * 4;
  localparam int FIELD_ADDR = SEL_ADDR + 1;
  localparam int BIT_CLR    = 0;
  localparam int BIT_WD_EN  = 0;
  localparam int BIT_HB_EN  = 8;
  localparam logic [CODE_W-1:0] CODE_TE = CODE_W'(NUM_TMR);

  typedef struct packed {
    logic               tick;
    logic [NUM_TMR-1:0] clr;
  } hbvsStrobes_t;

  typedef struct packed {
    logic              wdEn;
    logic              hbEn;
    logic [LOAD_W-1:0] load;
  } tmrCfg_t;

  // Field position of each output's code; downstream decode depends on it.
  function automatic int fieldOffset(input int idx);
    case (idx)
      0:       return 12;
      1:       return 8;
      2:       return 4;
      3:       return 19;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/hbvs_ctrl.sv
module hbvs_ctrl
  import hbvs_pkg::*;
#(
  parameter int PRESCALE_DIV = PRESCALE
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWr,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWrData,
  output logic [DATA_W-1:0]             regRdData,
  output hbvsStrobes_t                  strobes,
  output tmrCfg_t [NUM_TMR-1:0]         tmrCfg,
  output logic [NUM_OUT-1:0][CODE_W-1:0] selCode
);
  localparam int PS_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;

  logic [PS_W-1:0] psCnt;
  logic            tickNow;
  logic            selWrite;
  logic            fieldWrite;
  logic            unusedWrBits;

  assign unusedWrBits = ^{regWrData[31:28], regWrData[23], regWrData[18:16], regWrData[3]};

  // Tick prescaler
  assign tickNow = (psCnt == PS_W'(PRESCALE_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psCnt <= '0;
    else if (tickNow) psCnt <= '0;
    else psCnt <= psCnt + 1'b1;
  end

  assign strobes.tick = tickNow;
  assign selWrite     = regWr && (regAddr == ADDR_W'(SEL_ADDR));
  assign fieldWrite   = regWr && (regAddr == ADDR_W'(FIELD_ADDR));

  // Per-timer configuration registers and clear strobes
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmrRegs
    logic wrCtl, wrCtl2, wrLoad;
    assign wrCtl  = regWr && (regAddr == ADDR_W'(i * 4 + SUB_CTL));
    assign wrCtl2 = regWr && (regAddr == ADDR_W'(i * 4 + SUB_CTL2));
    assign wrLoad = regWr && (regAddr == ADDR_W'(i * 4 + SUB_LOAD));

    assign strobes.clr[i] = wrCtl && regWrData[BIT_CLR];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tmrCfg[i] <= '0;
      end else begin
        if (wrCtl2) begin
          tmrCfg[i].wdEn <= regWrData[BIT_WD_EN];
          tmrCfg[i].hbEn <= regWrData[BIT_HB_EN];
        end
        if (wrLoad) tmrCfg[i].load <= regWrData[LOAD_W-1:0];
      end
    end
  end

  // Per-output source codes
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_selRegs
    localparam int OFF = fieldOffset(k);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) selCode[k] <= '0;
      else if (selWrite) selCode[k] <= regWrData[OFF +: CODE_W];
      else if (fieldWrite && (regWrData[2:0] == 3'(k))) selCode[k] <= regWrData[7:4];
    end

    p_field_update_r8: assert property (@(posedge clk) disable iff (!rstN)
      (fieldWrite && (regWrData[2:0] != 3'(k))) |=> $stable(selCode[k]));
  end

  // Readback
  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (regAddr == ADDR_W'(i * 4 + SUB_CTL2)) begin
        regRdData[BIT_WD_EN] = tmrCfg[i].wdEn;
        regRdData[BIT_HB_EN] = tmrCfg[i].hbEn;
      end
      if (regAddr == ADDR_W'(i * 4 + SUB_LOAD)) regRdData[LOAD_W-1:0] = tmrCfg[i].load;
    end
    if (regAddr == ADDR_W'(SEL_ADDR)) begin
      for (int k = 0; k < NUM_OUT; k++) regRdData[fieldOffset(k) +: CODE_W] = selCode[k];
    end
  end

  p_tick_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    tickNow |=> !tickNow);
endmodule

// File: rtl/hbvs_timer.sv
module hbvs_timer
  import hbvs_pkg::*;
#(
  parameter int CNT_W = LOAD_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             clr,
  input  logic             wdEn,
  input  logic             hbEn,
  input  logic [CNT_W-1:0] load,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt;
  logic             idle;

  assign idle = !wdEn || (load == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (clr) begin
      cnt   <= load;
      pulse <= 1'b0;
    end else if (idle) begin
      pulse <= 1'b0;
    end else if (tick) begin
      if (cnt <= CNT_W'(1)) begin
        cnt   <= load;
        pulse <= hbEn;
      end else begin
        cnt   <= cnt - 1'b1;
        pulse <= 1'b0;
      end
    end
  end

  p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && idle) |=> $stable(cnt));
  p_no_pulse_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    idle |=> !pulse);
  p_pulse_needs_hb_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulse) |-> $past(hbEn));
  p_pulse_on_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulse) |-> $past(tick));
  p_count_on_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !tick) |=> $stable(cnt));
endmodule

// File: rtl/hbvs_datapath.sv
module hbvs_datapath
  import hbvs_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  hbvsStrobes_t                   strobes,
  input  tmrCfg_t [NUM_TMR-1:0]          tmrCfg,
  input  logic [NUM_OUT-1:0][CODE_W-1:0] selCode,
  input  logic                           teIn,
  output logic [NUM_OUT-1:0]             vsyncOut
);
  logic [NUM_TMR-1:0] tmrPulse;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    hbvs_timer #(.CNT_W(LOAD_W)) timer_i (
      .clk   (clk),
      .rstN  (rstN),
      .tick  (strobes.tick),
      .clr   (strobes.clr[i]),
      .wdEn  (tmrCfg[i].wdEn),
      .hbEn  (tmrCfg[i].hbEn),
      .load  (tmrCfg[i].load),
      .pulse (tmrPulse[i])
    );
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_route
    always_comb begin
      if (selCode[k] < CODE_TE) vsyncOut[k] = tmrPulse[selCode[k]];
      else if (selCode[k] == CODE_TE) vsyncOut[k] = teIn;
      else vsyncOut[k] = 1'b0;
    end

    p_undefined_low_r6: assert property (@(posedge clk) disable iff (!rstN)
      (selCode[k] > CODE_TE) |-> !vsyncOut[k]);
  end
endmodule

// File: rtl/hb_vsync_gen.sv
module hb_vsync_gen
  import hbvs_pkg::*;
#(
  parameter int PRESCALE_DIV = PRESCALE
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               teIn,
  output logic [NUM_OUT-1:0] vsyncOut
);
  hbvsStrobes_t                   strobes;
  tmrCfg_t [NUM_TMR-1:0]          tmrCfg;
  logic [NUM_OUT-1:0][CODE_W-1:0] selCode;

  hbvs_ctrl #(.PRESCALE_DIV(PRESCALE_DIV)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobes   (strobes),
    .tmrCfg    (tmrCfg),
    .selCode   (selCode)
  );

  hbvs_datapath datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .tmrCfg   (tmrCfg),
    .selCode  (selCode),
    .teIn     (teIn),
    .vsyncOut (vsyncOut)
  );
endmodule

// File: tb/hb_vsync_gen_tb.sv
module hb_vsync_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 16;
  localparam int NT = 5;
  localparam int SEL_A = 20;
  localparam int FLD_A = 21;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        teIn = 1'b0;
  logic [4:0]  vsyncOut;

  int    nChecks = 0;
  int    nFail = 0;
  bit    cmpOn = 0;
  string curReq = "R9";

  // Behavioural reference state
  int mPs;
  int mCnt [NT];
  int mLd  [NT];
  bit mEn  [NT];
  bit mHb  [NT];
  bit mPl  [NT];
  int mSel [NT];

  hb_vsync_gen dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .teIn(teIn), .vsyncOut(vsyncOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int offs(int k);
    int t[5] = '{12, 8, 4, 19, 24};
    return t[k];
  endfunction

  function automatic logic [4:0] modelVs();
    logic [4:0] v = '0;
    for (int k = 0; k < NT; k++) begin
      if (mSel[k] < 5) v[k] = mPl[mSel[k]];
      else if (mSel[k] == 5) v[k] = teIn;
    end
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPs = 0;
      for (int i = 0; i < NT; i++) begin
        mCnt[i] = 0; mLd[i] = 0; mEn[i] = 0; mHb[i] = 0; mPl[i] = 0; mSel[i] = 0;
      end
    end else begin
      bit tk;
      tk = (mPs == PRE - 1);
      mPs = tk ? 0 : mPs + 1;
      for (int i = 0; i < NT; i++) begin
        if (regWr && regAddr == 5'(i*4) && regWrData[0]) begin
          mCnt[i] = mLd[i]; mPl[i] = 0;
        end else if (!mEn[i] || mLd[i] == 0) begin
          mPl[i] = 0;
        end else if (tk) begin
          if (mCnt[i] <= 1) begin mCnt[i] = mLd[i]; mPl[i] = mHb[i]; end
          else begin mCnt[i] = mCnt[i] - 1; mPl[i] = 0; end
        end
      end
      if (regWr) begin
        for (int i = 0; i < NT; i++) begin
          if (regAddr == 5'(i*4+1)) begin mEn[i] = regWrData[0]; mHb[i] = regWrData[8]; end
          if (regAddr == 5'(i*4+2)) mLd[i] = int'(regWrData[15:0]);
        end
        if (regAddr == 5'(SEL_A))
          for (int k = 0; k < NT; k++) mSel[k] = int'((regWrData >> offs(k)) & 32'hF);
        if (regAddr == 5'(FLD_A) && regWrData[2:0] < 5)
          mSel[regWrData[2:0]] = int'(regWrData[7:4]);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (cmpOn) chk(curReq, {27'b0, vsyncOut}, {27'b0, modelVs()});

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); #1;
    regWr = 1'b1; regAddr = 5'(a); regWrData = d;
    @(negedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic rdChk(string req, int a, logic [31:0] exp);
    @(negedge clk); #1;
    regAddr = 5'(a);
    #2;
    chk(req, regRdData, exp);
  endtask

  task automatic fld(int idx, int code);
    wr(FLD_A, 32'((code << 4) | idx));
  endtask

  task automatic countHigh(int bitIdx, int cycles, output int highs);
    highs = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (vsyncOut[bitIdx]) highs++;
    end
  endtask

  task automatic waitRise(int bitIdx);
    @(negedge clk);
    while (vsyncOut[bitIdx]) @(negedge clk);
    while (!vsyncOut[bitIdx]) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int h;
    int t0;
    logic [31:0] selVal;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", {27'b0, vsyncOut}, 32'h0);
    rdChk("R9", 1, 0); rdChk("R9", 2, 0); rdChk("R9", SEL_A, 0);
    @(negedge clk); #1; rstN = 1'b1;
    cmpOn = 1;

    // R10: readback layout
    curReq = "R10";
    wr(2, 32'hFFFF_0003);
    wr(1, 32'hFFFF_FFFF);
    rdChk("R10", 2, 32'h3);
    rdChk("R10", 1, 32'h101);
    rdChk("R10", 0, 32'h0);

    // R2: periodic heartbeat from timer 0 on every output
    curReq = "R2";
    wr(SEL_A, 0);
    wr(0, 1);
    countHigh(0, 480, h);
    chk("R2", 32'(h >= 9*16), 32'h1);

    // R1: pulse width one tick
    curReq = "R1";
    wr(14, 2); wr(13, 32'h101); wr(12, 1); fld(3, 3);
    waitRise(3);
    h = 0;
    while (vsyncOut[3]) begin h++; @(negedge clk); end
    chk("R1", 32'(h), 32'd16);
    repeat (100) @(negedge clk);

    // R3: heartbeat off keeps output low, then on
    curReq = "R3";
    wr(6, 2); wr(5, 32'h001); wr(4, 1); fld(1, 1);
    countHigh(1, 200, h);
    chk("R3", 32'(h), 0);
    wr(5, 32'h101);
    repeat (150) @(negedge clk);

    // R4: disabled timer holds; zero load stays idle
    curReq = "R4";
    wr(1, 0);
    countHigh(0, 200, h);
    chk("R4", 32'(h), 0);
    wr(1, 32'h101);
    repeat (100) @(negedge clk);
    wr(10, 0); wr(9, 32'h101); fld(2, 2); wr(8, 1);
    countHigh(2, 200, h);
    chk("R4", 32'(h), 0);

    // R5: load change applies at reload
    curReq = "R5";
    wr(2, 6);
    waitRise(0);
    waitRise(0);
    t0 = 0;
    @(negedge clk);
    while (vsyncOut[0]) begin t0++; @(negedge clk); end
    while (!vsyncOut[0]) begin t0++; @(negedge clk); end
    chk("R5", 32'(t0 + 1), 32'd96);

    // R6: source codes
    curReq = "R6";
    wr(1, 0);
    fld(4, 5);
    @(negedge clk); #1; teIn = 1'b1; #2;
    chk("R6", {31'b0, vsyncOut[4]}, 32'h1);
    fld(4, 7);
    #2; chk("R6", {31'b0, vsyncOut[4]}, 32'h0);
    fld(4, 15);
    #2; chk("R6", {31'b0, vsyncOut[4]}, 32'h0);
    @(negedge clk); #1; teIn = 1'b0;

    // R7: field positions
    curReq = "R7";
    wr(5, 0); wr(13, 0); wr(9, 0);
    repeat (2) @(negedge clk);
    for (int k = 0; k < NT; k++) begin
      @(negedge clk); #1; teIn = 1'b0;
      wr(SEL_A, 32'(5) << offs(k));
      @(negedge clk); #1; teIn = 1'b1; #2;
      chk("R7", {27'b0, vsyncOut}, 32'(1 << k));
    end
    @(negedge clk); #1; teIn = 1'b0;
    selVal = 32'h0000_0000;
    for (int k = 0; k < NT; k++) selVal |= 32'(k + 1) << offs(k);
    wr(SEL_A, selVal | 32'hF080_0000);
    rdChk("R7", SEL_A, selVal);

    // R8: single-field update
    curReq = "R8";
    fld(2, 9);
    selVal = (selVal & ~(32'hF << offs(2))) | (32'h9 << offs(2));
    rdChk("R8", SEL_A, selVal);
    fld(6, 3);
    rdChk("R8", SEL_A, selVal);

    // R9: mid-run reset
    curReq = "R9";
    wr(1, 32'h101);
    repeat (60) @(negedge clk);
    cmpOn = 0;
    @(negedge clk); #1; rstN = 1'b0; #2;
    chk("R9", {27'b0, vsyncOut}, 32'h0);
    rdChk("R9", SEL_A, 0); rdChk("R9", 1, 0); rdChk("R9", 2, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule